// File: doc/BRIEF.md
# Mini UART Register Front End

This block is the software-visible face of a small UART. A processor reaches it over a 32-bit word-access register bus that decodes a 256-byte window. Bytes from the receive side arrive on a ready/valid byte stream and are held in a circular receive FIFO. The processor drains that FIFO through the data register. A write to the data register puts the byte out on a transmit byte stream at once. The transmitter is modelled as always drained, so it always reports idle and empty.

One level interrupt output combines two sources. The receive source is raised while its enable is set and the FIFO holds data. The transmit source is raised whenever its enable is set. Status registers report the FIFO occupancy in several encodings. Registers for line control, modem control, scratch and baud setup have no function here: they read as zero and ignore writes. Serialization, baud generation and any second serial function live outside this block.

Bus decode uses address bits [7:2] only. Read data is combinational and valid in the same cycle as `regRdEn`. All state changes take effect at the clock edge that ends the access cycle. The bus issues at most one read or one write per cycle.

Top module: `uart_regfront`

## Requirements
- R1: After reset the FIFO is empty (fill 0, head slot 0, storage zero), both interrupt enables are clear, `irq` is low, `rxReady` is high and `txValid` is low.
- R2: A write to offset 0x44 stores only bits [1:0] (bit 0 = receive enable, bit 1 = transmit enable). A read of 0x44 returns 0xC0 ORed with the stored bits.
- R3: `irq` is high exactly when (receive enable and fill count non-zero) or transmit enable. Offset 0x00 reads 1 when `irq` is high and 0 otherwise.
- R4: A read of offset 0x48 returns 0xC0, plus 0x4 if the FIFO is non-empty or else 0x2, plus 0x1 if no interrupt source is pending.
- R5: A write to 0x48 with bit 1 set empties the FIFO by zeroing the fill count, while the head slot is left alone. A write with bit 1 clear has no effect.
- R6: A read of offset 0x40 returns the byte at the head slot in bits [7:0], with the upper bits zero. If the FIFO is non-empty, the read also advances the head, wrapping modulo the depth, and decrements the count. On an empty FIFO it returns the stale head byte and changes nothing.
- R7: Offset 0x54 reads 0x60, with bit 0 set when the FIFO is non-empty.
- R8: Offset 0x64 reads 0x30E, with bit 0 set when the FIFO is non-empty and the fill count in bits [19:16].
- R9: Offset 0x04 reads 1 and offset 0x60 reads 3. Offsets 0x4C, 0x50, 0x58, 0x5C, 0x68 and every undecoded offset read 0, and writes to them change no state.
- R10: `rxReady` is high only while the fill count is below the depth (8). An accepted byte is stored in slot (head + count) mod depth. A byte offered while the FIFO is full is not stored.
- R11: A write to offset 0x40 drives `txData` with the written bits [7:0] and pulses `txValid` for exactly the next cycle.
- R12: When a byte is accepted in the same cycle as a popping data read, the count is unchanged and both operations take effect. When a byte is accepted in the same cycle as a flush, the FIFO ends up holding only that byte, at the head slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Byte address in the register window (bits [1:0] ignored) |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe for one cycle (a data read pops at the end of it) |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | Received byte is offered |
| rxReady | output | 1 | FIFO can accept a byte this cycle |
| txData | output | 8 | Transmitted byte |
| txValid | output | 1 | Transmitted byte valid, one cycle per data write |
| irq | output | 1 | Level interrupt request |

## Verification
Read data belongs to the access cycle itself and reflects state as of the previous edge. The bench therefore samples `regRdData` one nanosecond after the falling edge on which it drove the access. FIFO updates, flushes and enable writes appear on `irq`, `rxReady` and later reads one cycle after the access, because a single register stage lies on that path. `txValid` and `txData` follow a data write by exactly one cycle. The reference model advances on each rising edge and predicts every output for the next sampling point, and all outputs are compared on every cycle.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  // word indexes (byte offset >> 2) of the decoded registers
  localparam logic [5:0] W_SUMMARY = 6'h00;
  localparam logic [5:0] W_ENABLES = 6'h01;
  localparam logic [5:0] W_DATA    = 6'h10;
  localparam logic [5:0] W_IEN     = 6'h11;
  localparam logic [5:0] W_IDENT   = 6'h12;
  localparam logic [5:0] W_LSTAT   = 6'h15;
  localparam logic [5:0] W_CTRL    = 6'h18;
  localparam logic [5:0] W_XSTAT   = 6'h19;

  // control-to-datapath strobes, valid for one cycle
  typedef struct packed {
    logic popReq;    // data register read
    logic flushReq;  // identify write with bit 1 set
    logic txSend;    // data register write
    logic ierWr;     // enable register write
  } rf_strobe_t;
endpackage

// File: rtl/uart_rf_dp.sv
module uart_rf_dp
  import uart_rf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rf_strobe_t        strb,
  input  logic [DATA_W-1:0] wrByte,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [CNT_W-1:0]  fillCount,
  output logic [PTR_W-1:0]  headPtr,
  output logic [DATA_W-1:0] headByte,
  output logic [DATA_W-1:0] txData,
  output logic              txValid
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W:0]   LAST_C  = (PTR_W + 1)'(DEPTH - 1);

  logic [DATA_W-1:0] slotMem [DEPTH];
  logic              pushOk, popOk;
  logic [CNT_W-1:0]  baseCount;
  logic [PTR_W:0]    slotSum;
  logic [PTR_W-1:0]  pushSlot, headNext;

  assign rxReady  = fillCount < DEPTH_C;
  assign pushOk   = rxValid && rxReady;
  assign popOk    = strb.popReq && (fillCount != '0);
  assign baseCount = strb.flushReq ? '0 : fillCount;
  assign headByte = slotMem[headPtr];

  // tail slot = head + base count, wrapped modulo the depth
  always_comb begin
    slotSum  = (PTR_W + 1)'(headPtr) + (PTR_W + 1)'(baseCount);
    if (slotSum > LAST_C) pushSlot = PTR_W'(slotSum - (PTR_W + 1)'(DEPTH));
    else                  pushSlot = PTR_W'(slotSum);
    headNext = ((PTR_W + 1)'(headPtr) == LAST_C) ? '0 : headPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      fillCount <= '0;
      for (int i = 0; i < DEPTH; i++) slotMem[i] <= '0;
    end else begin
      if (pushOk) slotMem[pushSlot] <= rxData;
      if (popOk)  headPtr <= headNext;
      fillCount <= baseCount + CNT_W'(pushOk) - CNT_W'(popOk && !strb.flushReq);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= strb.txSend;
      if (strb.txSend) txData <= wrByte;
    end
  end
endmodule

// File: rtl/uart_rf_ctrl.sv
module uart_rf_ctrl
  import uart_rf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [31:0]       regWrData,
  input  logic [CNT_W-1:0]  fillCount,
  input  logic [DATA_W-1:0] headByte,
  output rf_strobe_t        strb,
  output logic [1:0]        ierBits,
  output logic              irq,
  output logic [31:0]       regRdData
);
  logic [5:0] wordIdx;
  logic       nonEmpty, rxPend, txPend;
  logic       unusedAddr;

  assign wordIdx    = regAddr[7:2];
  assign unusedAddr = ^regAddr[1:0];

  always_comb begin
    strb.popReq   = regRdEn && (wordIdx == W_DATA);
    strb.txSend   = regWrEn && (wordIdx == W_DATA);
    strb.ierWr    = regWrEn && (wordIdx == W_IEN);
    strb.flushReq = regWrEn && (wordIdx == W_IDENT) && regWrData[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ierBits <= 2'b00;
    else if (strb.ierWr) ierBits <= regWrData[1:0];
  end

  assign nonEmpty = fillCount != '0;
  assign rxPend   = ierBits[0] && nonEmpty;
  assign txPend   = ierBits[1];
  assign irq      = rxPend || txPend;

  always_comb begin
    regRdData = 32'h0;
    case (wordIdx)
      W_SUMMARY: regRdData = {31'h0, irq};
      W_ENABLES: regRdData = 32'h1;
      W_DATA:    regRdData = 32'(headByte);
      W_IEN:     regRdData = 32'hC0 | {30'h0, ierBits};
      W_IDENT:   regRdData = 32'hC0 | (nonEmpty ? 32'h4 : 32'h2) | {31'h0, !irq};
      W_LSTAT:   regRdData = 32'h60 | {31'h0, nonEmpty};
      W_CTRL:    regRdData = 32'h3;
      W_XSTAT:   regRdData = 32'h30E | {31'h0, nonEmpty} | (32'(fillCount) << 16);
      default:   regRdData = 32'h0;
    endcase
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  logic              regRdEn,
  output logic [31:0]       regRdData,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  output logic              irq
);
  rf_strobe_t        strb;
  logic [CNT_W-1:0]  fillCount;
  logic [PTR_W-1:0]  headPtr;
  logic [DATA_W-1:0] headByte;
  logic [1:0]        ierBits;

  uart_rf_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .fillCount(fillCount),
    .headByte(headByte), .strb(strb), .ierBits(ierBits), .irq(irq),
    .regRdData(regRdData)
  );

  uart_rf_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(regWrData[DATA_W-1:0]),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .fillCount(fillCount), .headPtr(headPtr), .headByte(headByte),
    .txData(txData), .txValid(txValid)
  );
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        regAddr,
  input logic              regWrEn,
  input logic [31:0]       regWrData,
  input logic              regRdEn,
  input logic              rxValid,
  input logic              rxReady,
  input logic [DATA_W-1:0] txData,
  input logic              txValid,
  input logic              irq,
  input logic [CNT_W-1:0]  fillCount,
  input logic [PTR_W-1:0]  headPtr,
  input logic [1:0]        ierBits
);
  logic dataRd, dataWr, flushWr;
  assign dataRd  = regRdEn && (regAddr[7:2] == 6'h10);
  assign dataWr  = regWrEn && (regAddr[7:2] == 6'h10);
  assign flushWr = regWrEn && (regAddr[7:2] == 6'h12) && regWrData[1];

  // R10: occupancy never exceeds the depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  // R10: a full FIFO with no pop or flush stays full and refuses bytes
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == CNT_W'(DEPTH) && !dataRd && !flushWr) |=> fillCount == CNT_W'(DEPTH) && !rxReady);

  // R3: transmit enable alone forces the interrupt
  a_r3_tx_irq: assert property (@(posedge clk) disable iff (!rstN)
    ierBits[1] |-> irq);

  // R11: a data write produces one transmit pulse carrying its byte
  a_r11_tx_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> txValid && txData == $past(regWrData[DATA_W-1:0]));

  // R6: a read of an empty FIFO with nothing arriving moves nothing
  a_r6_empty_no_pop: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0 && dataRd && !rxValid) |=> fillCount == '0 && $stable(headPtr));

  // R5: a flush with no arrival leaves the FIFO empty
  a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    (flushWr && !rxValid) |=> fillCount == '0);

  // R12: a simultaneous accept and pop keeps the count
  a_r12_push_pop: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady && dataRd && fillCount != '0 && !regWrEn) |=> $stable(fillCount));
endmodule

bind uart_regfront uart_regfront_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdEn(regRdEn), .rxValid(rxValid),
  .rxReady(rxReady), .txData(txData), .txValid(txValid), .irq(irq),
  .fillCount(fillCount), .headPtr(headPtr), .ierBits(ierBits)
);

// File: tb/uart_regfront_tb_top.sv
module uart_regfront_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic [7:0]  rxData = '0;
  logic        rxValid = 1'b0;
  logic        rxReady;
  logic [7:0]  txData;
  logic        txValid;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_regfront dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .irq(irq)
  );

  // behavioural reference state
  logic [7:0] mMem [DEPTH];
  int mHead, mCount, mIer;
  logic mTxV;
  logic [7:0] mTxD;

  function automatic logic mIrq();
    return ((mIer & 1) != 0 && mCount != 0) || ((mIer & 2) != 0);
  endfunction

  function automatic logic [31:0] mRead(input logic [7:0] a);
    logic ne;
    ne = mCount != 0;
    case (a[7:2])
      6'h00: return {31'h0, mIrq()};
      6'h01: return 32'h1;
      6'h10: return {24'h0, mMem[mHead]};
      6'h11: return 32'hC0 | 32'(mIer);
      6'h12: return 32'hC0 | (ne ? 32'h4 : 32'h2) | {31'h0, !mIrq()};
      6'h15: return 32'h60 | {31'h0, ne};
      6'h18: return 32'h3;
      6'h19: return 32'h30E | {31'h0, ne} | (32'(mCount) << 16);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus/stream cycle: drive at the falling edge, compare, then advance the model
  task automatic cyc(input logic wr, input logic rd, input logic [7:0] a,
                     input logic [31:0] wd, input logic rv, input logic [7:0] rd8,
                     input string tag);
    logic push, pop, flush;
    int slot;
    @(negedge clk);
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = wd;
    rxValid = rv; rxData = rd8;
    #1;
    if (rd) chk({tag, " rdData"}, regRdData, mRead(a));
    chk({tag, " irq R3"}, {31'h0, irq}, {31'h0, mIrq()});
    chk({tag, " rxReady R10"}, {31'h0, rxReady}, {31'h0, mCount < DEPTH});
    chk({tag, " txValid R11"}, {31'h0, txValid}, {31'h0, mTxV});
    if (mTxV) chk({tag, " txData R11"}, {24'h0, txData}, {24'h0, mTxD});
    @(posedge clk);
    push  = rv && (mCount < DEPTH);
    pop   = rd && (a[7:2] == 6'h10) && (mCount > 0);
    flush = wr && (a[7:2] == 6'h12) && wd[1];
    if (push) begin
      slot = (mHead + (flush ? 0 : mCount)) % DEPTH;
      mMem[slot] = rd8;
    end
    if (pop) mHead = (mHead + 1) % DEPTH;
    mCount = (flush ? 0 : mCount) + (push ? 1 : 0) - ((pop && !flush) ? 1 : 0);
    if (wr && a[7:2] == 6'h11) mIer = int'(wd[1:0]);
    mTxV = wr && (a[7:2] == 6'h10);
    if (mTxV) mTxD = wd[7:0];
  endtask

  task automatic rdReg(input logic [7:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 32'h0, 1'b0, 8'h0, tag);
  endtask
  task automatic wrReg(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b0, a, d, 1'b0, 8'h0, tag);
  endtask
  task automatic pushB(input logic [7:0] b, input string tag);
    cyc(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, b, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = 8'h00;
    mHead = 0; mCount = 0; mIer = 0; mTxV = 1'b0; mTxD = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state seen through the ports
    rdReg(8'h44, "R1 ier after reset");
    rdReg(8'h48, "R1 ident after reset");
    rdReg(8'h64, "R1 xstat after reset");
    rdReg(8'h40, "R1 data after reset");
    // R9: constants, unimplemented offsets, ignored writes
    rdReg(8'h04, "R9 enables");
    rdReg(8'h60, "R9 control");
    wrReg(8'h4C, 32'hFFFF_FFFF, "R9 lcr write");
    wrReg(8'h5C, 32'hFFFF_FFFF, "R9 scratch write");
    wrReg(8'h68, 32'hFFFF_FFFF, "R9 baud write");
    wrReg(8'h04, 32'h0, "R9 enables write");
    wrReg(8'h60, 32'h0, "R9 control write");
    rdReg(8'h4C, "R9 lcr read");
    rdReg(8'h50, "R9 mcr read");
    rdReg(8'h58, "R9 msr read");
    rdReg(8'h5C, "R9 scratch read");
    rdReg(8'h68, "R9 baud read");
    rdReg(8'hF0, "R9 undecoded read");
    rdReg(8'h44, "R9 ier unchanged");
    rdReg(8'h60, "R9 control unchanged");
    // R10: three bytes in, status views
    pushB(8'h11, "R10 push"); pushB(8'h22, "R10 push"); pushB(8'h33, "R10 push");
    rdReg(8'h54, "R7 lstat nonempty");
    rdReg(8'h64, "R8 xstat 3");
    rdReg(8'h48, "R4 ident no enable");
    // R2: enable write masks to two bits
    wrReg(8'h44, 32'hFF, "R2 ier write");
    rdReg(8'h44, "R2 ier read");
    rdReg(8'h00, "R3 summary");
    rdReg(8'h48, "R4 ident pending");
    wrReg(8'h44, 32'h1, "R2 rx only");
    // R6: ordered pops then empty reads
    rdReg(8'h40, "R6 pop1"); rdReg(8'h40, "R6 pop2"); rdReg(8'h40, "R6 pop3");
    rdReg(8'h00, "R3 summary empty");
    rdReg(8'h40, "R6 empty stale");
    rdReg(8'h40, "R6 empty stale again");
    rdReg(8'h48, "R4 ident idle");
    // R10: fill to the depth with wrap, then offer while full
    for (int i = 0; i < DEPTH; i++) pushB(8'(8'hA0 + i * 7), "R10 fill");
    rdReg(8'h64, "R8 xstat full");
    pushB(8'hEE, "R10 offer while full");
    pushB(8'hEF, "R10 offer while full");
    rdReg(8'h64, "R8 xstat still full");
    // R12: accept and pop in one cycle
    rdReg(8'h40, "R6 pop from full");
    cyc(1'b0, 1'b1, 8'h40, 32'h0, 1'b1, 8'h5A, "R12 push+pop");
    cyc(1'b0, 1'b1, 8'h40, 32'h0, 1'b1, 8'h5B, "R12 push+pop");
    rdReg(8'h64, "R12 count kept");
    // R5: flush only with bit 1
    wrReg(8'h48, 32'hFFFF_FFFD, "R5 no flush");
    rdReg(8'h64, "R5 count intact");
    wrReg(8'h48, 32'h2, "R5 flush");
    rdReg(8'h64, "R5 count zero");
    rdReg(8'h40, "R5 head kept stale");
    // R12: flush with an arriving byte
    pushB(8'h71, "R12 pre");
    cyc(1'b1, 1'b0, 8'h48, 32'h2, 1'b1, 8'h72, "R12 flush+push");
    rdReg(8'h64, "R12 one left");
    rdReg(8'h40, "R12 survivor");
    // R11: transmit pulses, back to back and isolated
    wrReg(8'h40, 32'h0000_01A5, "R11 tx");
    wrReg(8'h40, 32'h0000_003C, "R11 tx b2b");
    rdReg(8'h54, "R11 gap");
    rdReg(8'h54, "R7 lstat empty");
    wrReg(8'h44, 32'h2, "R3 tx enable");
    rdReg(8'h48, "R4 ident tx");
    wrReg(8'h44, 32'h0, "R3 disable");
    rdReg(8'h00, "R3 summary off");
    // sweep of mixed traffic
    for (int i = 0; i < 60; i++)
      cyc(1'b0, (i % 3) == 0, 8'h40, 32'h0, (i % 2) == 0, 8'(i * 13 + 1), "R10 mixed");
    rdReg(8'h64, "R8 xstat mixed");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule